// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit core: two external request lines, two timer overflow flags and one serial source, which is the OR of a receive flag and a transmit flag. Software-visible state is limited to two registers:

- An enable register, with a global enable and one enable bit per source.
- A priority register, with one bit per source that puts the source at the high level.

Each external line has its own trigger-mode input. In level mode the active-low line requests directly. In edge mode a falling edge sets a pending latch.

The core pulses `insn_boundary` at the end of every instruction. On that strobe the controller picks the winning pending source, if the nesting rules allow it. It then raises `irq_req` together with the source's vector address and holds both until the core pulses `irq_ack`. The acknowledge marks the matching level as in service. A `reti_pulse` from the core clears the highest level in service. After each return, the controller lets at least one instruction of the interrupted program complete before it takes another interrupt.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the enable and priority registers are zero, no level is in service, and no request is issued even with every source active.
- R2: When enable bit 7 (global) is 0, no source is taken, whatever the values of enable bits 4..0.
- R3: Source index order is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. The enable bit and the priority bit of a source sit at its index. Its vector is 0x0003 + 8 × index, so the vectors are 0003, 000B, 0013, 001B and 0023.
- R4: Among pending, enabled sources at the same level, the lowest index wins.
- R5: A pending source whose priority bit is 1 wins over any source whose priority bit is 0, regardless of index.
- R6: A high-level request is accepted while only a low-level handler is in service. A low-level request is accepted only when no handler is in service.
- R7: While a high-level handler is in service, no request is accepted.
- R8: A return pulse clears only the highest level in service. A low-level handler that was preempted remains in service afterwards.
- R9: After a return pulse, the next boundary strobe accepts nothing. A request can be accepted from the strobe after that one.
- R10: In edge mode (trigger bit 1), a falling edge on the line sets a pending flag that persists after the line returns high. The flag clears when that source's request is acknowledged. In level mode (trigger bit 0), the request follows the live line and nothing is latched.
- R11: Selection happens only on a boundary strobe. `irq_req` and `irq_vector` then hold steady until `irq_ack`. One cycle after the acknowledge, `irq_req` is low and the vector reads 0.
- R12: The serial source requests when either the receive flag or the transmit flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable data: bit 7 global, bits 4..0 per source |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 5 | Priority data: 1 = high level |
| ext_edge_mode | input | 2 | Per external line: 1 = falling edge, 0 = level |
| ext_n | input | 2 | External request lines, active low |
| tmr_flag | input | 2 | Timer overflow flags (timer 0 in bit 0) |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| insn_boundary | input | 1 | Instruction-boundary strobe |
| irq_ack | input | 1 | Core acknowledge of the current request |
| reti_pulse | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Vector address of the request |

## Verification
Every result is registered. A boundary strobe sampled at clock edge k shows up on `irq_req` and `irq_vector` right after edge k. The same one-edge rule applies to an acknowledge dropping the request, a return clearing a level, and a falling edge setting an edge-mode pending flag. A level-mode line feeds the selection with no delay. The bench changes inputs on falling clock edges and reads outputs on the following falling edge, so exactly one rising edge lies between a stimulus and its check. A behavioural model in the bench advances on that same rising edge and is compared on every falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_COUNT  = 5;
  localparam int EXT_COUNT  = 2;
  localparam int VEC_WIDTH  = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int IDX_W      = $clog2(SRC_COUNT);

  // vector address for a source index
  function automatic logic [VEC_WIDTH-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_WIDTH'(VEC_BASE + VEC_STRIDE * int'(idx));
  endfunction

  // index of the lowest set bit (0 when none is set)
  function automatic logic [IDX_W-1:0] lowest_set(input logic [SRC_COUNT-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond #(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] line_n,
  input  logic [NEXT-1:0] edge_mode,
  input  logic [NEXT-1:0] clr,
  output logic [NEXT-1:0] req
);
  logic [NEXT-1:0] prev_q;
  logic [NEXT-1:0] pend_q;
  logic [NEXT-1:0] fall;

  for (genvar e = 0; e < NEXT; e++) begin : g_line
    assign fall[e] = prev_q[e] & ~line_n[e];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[e] <= 1'b1;
        pend_q[e] <= 1'b0;
      end else begin
        prev_q[e] <= line_n[e];
        if (!edge_mode[e])  pend_q[e] <= 1'b0;
        else if (fall[e])   pend_q[e] <= 1'b1;
        else if (clr[e])    pend_q[e] <= 1'b0;
      end
    end

    assign req[e] = edge_mode[e] ? pend_q[e] : ~line_n[e];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = SRC_COUNT
) (
  input  logic [NSRC-1:0]  eligible,
  input  logic [NSRC-1:0]  prio,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_high
);
  logic [NSRC-1:0] hi_set;
  logic [NSRC-1:0] lo_set;

  assign hi_set = eligible & prio;
  assign lo_set = eligible & ~prio;

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    grant_high  = 1'b0;
    if (!ins_hi && |hi_set) begin
      grant_valid = 1'b1;
      grant_idx   = lowest_set(hi_set);
      grant_high  = 1'b1;
    end else if (!ins_hi && !ins_lo && |lo_set) begin
      grant_valid = 1'b1;
      grant_idx   = lowest_set(lo_set);
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hi,
  input  logic set_lo,
  input  logic reti,
  output logic ins_hi,
  output logic ins_lo
);
  logic hi_after_ret;
  logic lo_after_ret;

  // a return drops the highest level that is active
  assign hi_after_ret = ins_hi & ~reti;
  assign lo_after_ret = ins_lo & ~(reti & ~ins_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_after_ret | set_hi;
      ins_lo <= lo_after_ret | set_lo;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_we,
  input  logic [7:0]           en_wdata,
  input  logic                 pri_we,
  input  logic [4:0]           pri_wdata,
  input  logic [1:0]           ext_edge_mode,
  input  logic [1:0]           ext_n,
  input  logic [1:0]           tmr_flag,
  input  logic                 ser_rx,
  input  logic                 ser_tx,
  input  logic                 insn_boundary,
  input  logic                 irq_ack,
  input  logic                 reti_pulse,
  output logic                 irq_req,
  output logic [VEC_WIDTH-1:0] irq_vector
);
  localparam int GIE_BIT = 7;

  logic                 gie_q;
  logic [SRC_COUNT-1:0] ien_q;
  logic [SRC_COUNT-1:0] prio_q;
  logic                 req_q;
  logic [VEC_WIDTH-1:0] vec_q;
  logic [IDX_W-1:0]     sel_idx_q;
  logic                 sel_hi_q;
  logic                 hold_off_q;

  logic [EXT_COUNT-1:0] ext_req;
  logic [EXT_COUNT-1:0] ext_clr;
  logic [SRC_COUNT-1:0] src_raw;
  logic [SRC_COUNT-1:0] eligible;
  logic                 grant_valid;
  logic [IDX_W-1:0]     grant_idx;
  logic                 grant_high;
  logic                 ins_hi;
  logic                 ins_lo;
  logic                 take_now;
  logic                 ack_fire;

  assign ack_fire = req_q & irq_ack;

  for (genvar e = 0; e < EXT_COUNT; e++) begin : g_clr
    assign ext_clr[e] = ack_fire && (sel_idx_q == IDX_W'(2 * e));
  end

  irq_ext_cond #(.NEXT(EXT_COUNT)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_n    (ext_n),
    .edge_mode (ext_edge_mode),
    .clr       (ext_clr),
    .req       (ext_req)
  );

  // fixed polling order: ext0, tmr0, ext1, tmr1, serial
  assign src_raw  = {ser_rx | ser_tx, tmr_flag[1], ext_req[1], tmr_flag[0], ext_req[0]};
  assign eligible = src_raw & ien_q & {SRC_COUNT{gie_q}};

  irq_arbiter #(.NSRC(SRC_COUNT)) u_arb (
    .eligible    (eligible),
    .prio        (prio_q),
    .ins_hi      (ins_hi),
    .ins_lo      (ins_lo),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_high  (grant_high)
  );

  irq_inservice u_ins (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_hi (ack_fire & sel_hi_q),
    .set_lo (ack_fire & ~sel_hi_q),
    .reti   (reti_pulse),
    .ins_hi (ins_hi),
    .ins_lo (ins_lo)
  );

  assign take_now = insn_boundary & ~req_q & ~hold_off_q & grant_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      ien_q      <= '0;
      prio_q     <= '0;
      req_q      <= 1'b0;
      vec_q      <= '0;
      sel_idx_q  <= '0;
      sel_hi_q   <= 1'b0;
      hold_off_q <= 1'b0;
    end else begin
      if (en_we) begin
        gie_q <= en_wdata[GIE_BIT];
        ien_q <= en_wdata[SRC_COUNT-1:0];
      end
      if (pri_we) prio_q <= pri_wdata;

      if (reti_pulse)         hold_off_q <= 1'b1;
      else if (insn_boundary) hold_off_q <= 1'b0;

      if (take_now) begin
        req_q     <= 1'b1;
        vec_q     <= vec_of(grant_idx);
        sel_idx_q <= grant_idx;
        sel_hi_q  <= grant_high;
      end else if (ack_fire) begin
        req_q <= 1'b0;
        vec_q <= '0;
      end
    end
  end

  assign irq_req    = req_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_boundary,
  input logic        irq_ack,
  input logic        irq_req,
  input logic [15:0] irq_vector,
  input logic        gie,
  input logic        ins_hi,
  input logic        hold_off
);
  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector)));

  p_drop_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!irq_req && irq_vector == 16'h0000));

  p_only_on_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_boundary));

  p_global_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(gie));

  p_high_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !$past(ins_hi));

  p_gap_after_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !$past(hold_off));

  p_vector_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 16'h0023));
endmodule

bind irq_ctrl_top irq_ctrl_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .irq_ack       (irq_ack),
  .irq_req       (irq_req),
  .irq_vector    (irq_vector),
  .gie           (gie_q),
  .ins_hi        (ins_hi),
  .hold_off      (hold_off_q)
);

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic        pri_we = 1'b0;
  logic [4:0]  pri_wdata = '0;
  logic [1:0]  ext_edge_mode = '0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_flag = '0;
  logic        ser_rx = 1'b0;
  logic        ser_tx = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        irq_ack = 1'b0;
  logic        reti_pulse = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata), .ext_edge_mode(ext_edge_mode),
    .ext_n(ext_n), .tmr_flag(tmr_flag), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .insn_boundary(insn_boundary), .irq_ack(irq_ack), .reti_pulse(reti_pulse),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // ---------------- behavioural reference model ----------------
  int m_en, m_pri, m_req, m_vec, m_idx, m_lvl, m_act_hi, m_act_lo, m_gap;
  int m_pend[2];
  int m_prev[2];

  always @(posedge clk) begin
    int src[5];
    int pick, plvl;
    if (!rst_n) begin
      m_en = 0; m_pri = 0; m_req = 0; m_vec = 0; m_idx = 0; m_lvl = 0;
      m_act_hi = 0; m_act_lo = 0; m_gap = 0;
      for (int i = 0; i < 2; i++) begin m_pend[i] = 0; m_prev[i] = 1; end
    end else begin
      for (int i = 0; i < 2; i++)
        src[2*i] = ext_edge_mode[i] ? m_pend[i] : (ext_n[i] == 1'b0);
      src[1] = tmr_flag[0];
      src[3] = tmr_flag[1];
      src[4] = ser_rx || ser_tx;
      pick = -1; plvl = 0;
      if (insn_boundary && !m_req && !m_gap && m_en[7]) begin
        for (int lvl = 1; lvl >= 0; lvl--) begin
          if (pick < 0 && !m_act_hi && (lvl == 1 || !m_act_lo))
            for (int i = 0; i < 5; i++)
              if (pick < 0 && src[i] != 0 && m_en[i] && m_pri[i] == lvl) begin
                pick = i; plvl = lvl;
              end
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (!ext_edge_mode[i]) m_pend[i] = 0;
        else if (m_prev[i] == 1 && ext_n[i] == 1'b0) m_pend[i] = 1;
        else if (m_req && irq_ack && m_idx == 2*i) m_pend[i] = 0;
        m_prev[i] = ext_n[i];
      end
      if (reti_pulse) begin
        if (m_act_hi) m_act_hi = 0; else m_act_lo = 0;
      end
      if (pick >= 0) begin
        m_req = 1; m_vec = 3 + 8*pick; m_idx = pick; m_lvl = plvl;
      end else if (m_req && irq_ack) begin
        m_req = 0; m_vec = 0;
        if (m_lvl) m_act_hi = 1; else m_act_lo = 1;
      end
      if (reti_pulse) m_gap = 1; else if (insn_boundary) m_gap = 0;
      if (en_we) m_en = en_wdata & 8'h9F;
      if (pri_we) m_pri = pri_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_req !== m_req[0] || irq_vector !== m_vec[15:0]) begin
        fails++;
        $display("FAIL R11 model compare: req=%0b vec=%h expected req=%0b vec=%h",
                 irq_req, irq_vector, m_req[0], m_vec[15:0]);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic expect_out(input string tag, input bit er, input logic [15:0] ev);
    checks++;
    if (irq_req !== er || irq_vector !== ev) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vector, er, ev);
    end
  endtask

  task automatic boundary();
    @(negedge clk) insn_boundary = 1'b1;
    @(negedge clk) insn_boundary = 1'b0;
  endtask
  task automatic ack();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask
  task automatic reti();
    @(negedge clk) reti_pulse = 1'b1;
    @(negedge clk) reti_pulse = 1'b0;
  endtask
  task automatic wr_en(input logic [7:0] v);
    @(negedge clk) begin en_we = 1'b1; en_wdata = v; end
    @(negedge clk) en_we = 1'b0;
  endtask
  task automatic wr_pri(input logic [4:0] v);
    @(negedge clk) begin pri_we = 1'b1; pri_wdata = v; end
    @(negedge clk) pri_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all sources active, nothing issued
    tmr_flag = 2'b11; ser_rx = 1'b1;
    boundary();
    expect_out("R1 reset no request", 1'b0, 16'h0000);
    // R2: individual enables without global
    wr_en(8'h1F);
    boundary();
    expect_out("R2 global clear", 1'b0, 16'h0000);
    // R4 / R3: timer0, timer1, serial pending at low level -> timer0
    wr_en(8'h9F);
    boundary();
    expect_out("R4 lowest index wins", 1'b1, 16'h000B);
    // R11: held without ack, further boundary does not change it
    boundary();
    repeat (2) @(negedge clk);
    expect_out("R11 held until ack", 1'b1, 16'h000B);
    ack();
    expect_out("R11 dropped after ack", 1'b0, 16'h0000);
    // R6: low handler active, low request blocked
    boundary();
    expect_out("R6 low blocked by low", 1'b0, 16'h0000);
    // R6 / R5: serial high preempts low handler
    wr_pri(5'b10000);
    boundary();
    expect_out("R6 high preempts low", 1'b1, 16'h0023);
    ack();
    // R7: nothing while high in service
    wr_pri(5'b11111);
    boundary();
    expect_out("R7 high in service blocks", 1'b0, 16'h0000);
    wr_pri(5'b00000);
    // R8 / R9
    reti();
    boundary();
    expect_out("R9 gap after return", 1'b0, 16'h0000);
    boundary();
    expect_out("R8 low still in service", 1'b0, 16'h0000);
    reti();
    boundary();
    expect_out("R9 gap after second return", 1'b0, 16'h0000);
    boundary();
    expect_out("R9 taken after gap", 1'b1, 16'h000B);
    ack(); reti(); boundary();
    // R5: timer1 high beats timer0 low
    wr_pri(5'b01000);
    boundary();
    expect_out("R5 high beats lower index", 1'b1, 16'h001B);
    ack(); reti(); boundary();
    wr_pri(5'b00000);
    // R12: serial via transmit flag only
    tmr_flag = 2'b00; ser_rx = 1'b0; ser_tx = 1'b1;
    wr_en(8'h90);
    boundary();
    expect_out("R12 transmit flag requests", 1'b1, 16'h0023);
    ack(); reti(); boundary();
    ser_tx = 1'b0;
    // R10 edge mode on external 0
    ext_edge_mode = 2'b01;
    wr_en(8'h81);
    @(negedge clk) ext_n[0] = 1'b0;
    @(negedge clk) ext_n[0] = 1'b1;
    repeat (3) @(negedge clk);
    boundary();
    expect_out("R10 edge latched", 1'b1, 16'h0003);
    ack(); reti(); boundary();
    boundary();
    expect_out("R10 latch cleared by ack", 1'b0, 16'h0000);
    // R10 level mode on external 1
    ext_edge_mode = 2'b00;
    wr_en(8'h84);
    @(negedge clk) ext_n[1] = 1'b0;
    @(negedge clk) ext_n[1] = 1'b1;
    boundary();
    expect_out("R10 level not latched", 1'b0, 16'h0000);
    @(negedge clk) ext_n[1] = 1'b0;
    boundary();
    expect_out("R10 level live R3 vector", 1'b1, 16'h0013);
    ack(); reti();
    @(negedge clk) ext_n[1] = 1'b1;
    boundary();
    boundary();
    expect_out("R10 level released", 1'b0, 16'h0000);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule